// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes received frames from a byte stream (one byte per accepted beat, with start-of-frame, end-of-frame and error flags) and stores each frame in a host buffer. The buffers are described by a ring of descriptors in host memory. The block reaches that memory through a word-wide master port. Each descriptor is four 32-bit words laid back to back:

- word 0 is the status and ownership word;
- word 1 holds the buffer size and the end-of-ring flag;
- word 2 holds the buffer's byte address;
- word 3 is not used.

A run bit starts and stops reception. A synchronous software-reset input returns the engine to stopped and rewinds it to the programmed ring base.

When a frame begins, the engine stalls the stream and reads the descriptor's ownership word. A descriptor owned by the engine has its control and buffer words fetched. The frame bytes are then packed little-endian into words and written with byte enables. Finally a status word is written back with the ownership bit cleared, which returns the descriptor to the host.

A descriptor that the host still holds causes the frame to be drained and discarded. In that case a saturating missed-frame counter is bumped, and the same descriptor is read again for the next frame. After a completed descriptor the engine moves 16 bytes ahead, or back to the ring base when that descriptor carries the end-of-ring flag.

Top module: `rx_desc_ring`

## Requirements
- R1: After power-on reset, and in the cycle after `soft_rst` is sampled high, `proc_state` reads 0 and `missed_frames` reads 0. The next descriptor used is then the one at `ring_base`.
- R2: While stopped (`proc_state` 0), the engine issues no memory request and accepts every stream byte (`rx_ready`=1), discarding it.
- R3: On a start-of-frame byte the engine reads word 0 at the descriptor address D (bit 31 = ownership, 1 = engine owns). An owned descriptor is followed by reads of D+4 (buffer size in bits 10:0, end-of-ring in bit 25) and D+8 (buffer byte address), so exactly 3 reads happen. An unowned descriptor costs exactly 1 read.
- R4: Stored byte k of a frame lands at byte address buffer+k, little-endian within 32-bit words. Only written byte lanes change.
- R5: On completion the engine writes word 0 at D with these fields: bit 31 = 0, bits 30:16 = number of bytes stored, bit 15 = error summary, bit 8 = 1, and all other bits 0.
- R6: When a frame is longer than the buffer size, only the first size bytes are written and the bytes after the buffer stay untouched. The stored length equals the size and bit 15 is set.
- R7: An error flag on any byte of a frame sets bit 15 of that frame's status word.
- R8: The next descriptor is D+16, or `ring_base` after a descriptor whose end-of-ring bit is set. Descriptors other than the current one are not modified.
- R9: A frame whose descriptor is not owned is consumed without any write. `missed_frames` then increments, saturating at all ones, and the same descriptor is read for the next frame.
- R10: A memory request keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack`.
- R11: `proc_state` encodes the engine's phase as follows: 0 stopped, 1 fetching a descriptor, 2 waiting for a frame, 3 receiving data, 4 writing status, 5 dropping a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_rst | input | 1 | Synchronous software reset to stopped |
| rx_enable | input | 1 | Run bit: receive while high |
| ring_base | input | AW | Byte address of the first descriptor |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | 8 | Stream byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_err | input | 1 | Byte carries an error |
| rx_ready | output | 1 | Engine accepts the byte this cycle |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| proc_state | output | 3 | Engine phase code |
| missed_frames | output | MISS_W | Saturating count of dropped frames |

## Verification
Two functions can fall in the same cycle:

- the buffer-full cut-off, which turns further bytes into discards and sets the error summary;
- the end-of-frame flush of a partly filled word.

Both happen together when the last byte of a frame arrives exactly at, or just past, the buffer size while a word still holds unwritten lanes. The bench provokes this by sweeping frame lengths from 1 to 45 across buffers of 5, 37 and 64 bytes, with memory acknowledges alternately immediate and irregularly delayed. Each outcome is judged from the status word's length and error bit, from the stored bytes, and from the untouched guard bytes beyond the stored length.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    // descriptor layout and status fields
    localparam int OWN_BIT     = 31;
    localparam int EOR_BIT     = 25;
    localparam int LEN_W       = 15;
    localparam int ES_BIT      = 15;
    localparam int LS_BIT      = 8;
    localparam int DESC_STRIDE = 16;
    localparam int CTL_OFS     = 4;
    localparam int BUF_OFS     = 8;
    localparam int LANES       = 4;
    localparam int DW          = 8 * LANES;

    // engine phase codes seen at proc_state
    localparam logic [2:0] PS_STOPPED = 3'd0;
    localparam logic [2:0] PS_FETCH   = 3'd1;
    localparam logic [2:0] PS_WAIT    = 3'd2;
    localparam logic [2:0] PS_RECV    = 3'd3;
    localparam logic [2:0] PS_CLOSE   = 3'd4;
    localparam logic [2:0] PS_DROP    = 3'd5;

    typedef enum logic [3:0] {
        ST_STOP   = 4'd0,
        ST_IDLE   = 4'd1,
        ST_RD_OWN = 4'd2,
        ST_RD_CTL = 4'd3,
        ST_RD_BUF = 4'd4,
        ST_RECV   = 4'd5,
        ST_WR_DAT = 4'd6,
        ST_WR_STS = 4'd7,
        ST_DROP   = 4'd8
    } eng_st_e;

    function automatic logic [DW-1:0] make_status(input logic [LEN_W-1:0] len,
                                                  input logic es);
        logic [DW-1:0] w;
        w                        = '0;
        w[LEN_W+15:16]           = len;
        w[ES_BIT]                = es;
        w[LS_BIT]                = 1'b1;
        w[OWN_BIT]               = 1'b0;
        return w;
    endfunction

    function automatic logic [2:0] phase_of(input eng_st_e st);
        case (st)
            ST_STOP:                         return PS_STOPPED;
            ST_RD_OWN, ST_RD_CTL, ST_RD_BUF: return PS_FETCH;
            ST_IDLE:                         return PS_WAIT;
            ST_RECV, ST_WR_DAT:              return PS_RECV;
            ST_WR_STS:                       return PS_CLOSE;
            default:                         return PS_DROP;
        endcase
    endfunction

endpackage

// File: rtl/rxd_miss_ctr.sv
module rxd_miss_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && cnt_q != TOP)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R9
    miss_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count >= $past(count)));

endmodule

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic          wrap,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] desc
);
    import rxd_pkg::*;

    localparam logic [AW-1:0] STEP = AW'(DESC_STRIDE);

    logic [AW-1:0] desc_d, desc_q;

    always_comb begin
        desc_d = desc_q;
        if (load)
            desc_d = base;
        else if (advance)
            desc_d = wrap ? base : desc_q + STEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) desc_q <= '0;
        else        desc_q <= desc_d;
    end

    assign desc = desc_q;

endmodule

// File: rtl/rxd_lane_pack.sv
module rxd_lane_pack #(
    parameter int LN = 4
) (
    input  logic [$clog2(LN)-1:0] lane,
    input  logic [7:0]            din,
    input  logic [8*LN-1:0]       word_i,
    input  logic [LN-1:0]         be_i,
    output logic [8*LN-1:0]       word_o,
    output logic [LN-1:0]         be_o
);
    for (genvar l = 0; l < LN; l++) begin : g_lane
        localparam logic [$clog2(LN)-1:0] IDX = l[$clog2(LN)-1:0];
        assign word_o[8*l +: 8] = (lane == IDX) ? din : word_i[8*l +: 8];
        assign be_o[l]          = be_i[l] | (lane == IDX);
    end
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring #(
    parameter int AW     = 32,
    parameter int BSZ_W  = 11,
    parameter int MISS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              rx_enable,
    input  logic [AW-1:0]     ring_base,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_err,
    output logic              rx_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic [2:0]        proc_state,
    output logic [MISS_W-1:0] missed_frames
);
    import rxd_pkg::*;

    localparam int CNT_W = BSZ_W;
    localparam int LW    = $clog2(LANES);

    typedef struct packed {
        eng_st_e          st;
        logic [AW-1:0]    bufa;
        logic [AW-1:0]    waddr;
        logic [CNT_W-1:0] bsize;
        logic [CNT_W-1:0] cnt;
        logic             eor;
        logic             trunc;
        logic             ferr;
        logic             eof;
        logic [DW-1:0]    wword;
        logic [LANES-1:0] wbe;
    } ctl_t;

    ctl_t q, d;

    logic [AW-1:0]    desc;
    logic             ptr_load, ptr_adv, miss_inc;
    logic [DW-1:0]    pk_word;
    logic [LANES-1:0] pk_be;
    logic             store;
    logic [CNT_W-1:0] word_ofs;

    rxd_ring_ptr #(.AW(AW)) i_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ptr_load),
        .advance (ptr_adv),
        .wrap    (q.eor),
        .base    (ring_base),
        .desc    (desc)
    );

    rxd_miss_ctr #(.W(MISS_W)) i_miss (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .inc   (miss_inc),
        .count (missed_frames)
    );

    rxd_lane_pack #(.LN(LANES)) i_pack (
        .lane   (q.cnt[LW-1:0]),
        .din    (rx_data),
        .word_i (q.wword),
        .be_i   (q.wbe),
        .word_o (pk_word),
        .be_o   (pk_be)
    );

    assign store    = (q.cnt < q.bsize);
    assign word_ofs = {q.cnt[CNT_W-1:LW], {LW{1'b0}}};
    assign ptr_load = soft_rst || (q.st == ST_STOP && rx_enable);

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc;
        mem_wdata = '0;
        mem_be    = '1;
        rx_ready  = 1'b0;
        miss_inc  = 1'b0;
        ptr_adv   = 1'b0;

        case (q.st)
            ST_STOP: begin
                rx_ready = 1'b1;
                if (rx_enable) d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (!rx_enable) begin
                    rx_ready = 1'b1;
                    d.st     = ST_STOP;
                end else begin
                    rx_ready = !(rx_valid && rx_sof);
                    if (rx_valid && rx_sof) d.st = ST_RD_OWN;
                end
            end
            ST_RD_OWN: begin
                mem_req  = 1'b1;
                mem_addr = desc;
                if (mem_ack) begin
                    if (mem_rdata[OWN_BIT]) begin
                        d.st = ST_RD_CTL;
                    end else begin
                        miss_inc = 1'b1;
                        d.st     = ST_DROP;
                    end
                end
            end
            ST_RD_CTL: begin
                mem_req  = 1'b1;
                mem_addr = desc + AW'(CTL_OFS);
                if (mem_ack) begin
                    d.bsize = mem_rdata[CNT_W-1:0];
                    d.eor   = mem_rdata[EOR_BIT];
                    d.st    = ST_RD_BUF;
                end
            end
            ST_RD_BUF: begin
                mem_req  = 1'b1;
                mem_addr = desc + AW'(BUF_OFS);
                if (mem_ack) begin
                    d.bufa  = mem_rdata[AW-1:0];
                    d.cnt   = '0;
                    d.trunc = 1'b0;
                    d.ferr  = 1'b0;
                    d.eof   = 1'b0;
                    d.wbe   = '0;
                    d.st    = ST_RECV;
                end
            end
            ST_RECV: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    d.ferr = q.ferr | rx_err;
                    d.eof  = rx_eof;
                    if (store) begin
                        d.wword = pk_word;
                        d.wbe   = pk_be;
                        d.cnt   = q.cnt + 1'b1;
                        d.waddr = q.bufa + AW'(word_ofs);
                    end else begin
                        d.trunc = 1'b1;
                    end
                    if ((store && q.cnt[LW-1:0] == LW'(LANES - 1)) ||
                        (rx_eof && d.wbe != '0))
                        d.st = ST_WR_DAT;
                    else if (rx_eof)
                        d.st = ST_WR_STS;
                end
            end
            ST_WR_DAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.waddr;
                mem_wdata = q.wword;
                mem_be    = q.wbe;
                if (mem_ack) begin
                    d.wbe = '0;
                    d.st  = q.eof ? ST_WR_STS : ST_RECV;
                end
            end
            ST_WR_STS: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc;
                mem_wdata = make_status(LEN_W'(q.cnt), q.ferr | q.trunc);
                if (mem_ack) begin
                    ptr_adv = 1'b1;
                    d.st    = ST_IDLE;
                end
            end
            ST_DROP: begin
                rx_ready = 1'b1;
                if (rx_valid && rx_eof) d.st = ST_IDLE;
            end
            default: d.st = ST_STOP;
        endcase

        if (soft_rst) d.st = ST_STOP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign proc_state = phase_of(q.st);

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !soft_rst) |=>
        (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R2
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_state == PS_STOPPED) |-> !mem_req);

    // R1
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (proc_state == PS_STOPPED && missed_frames == '0));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RECV) |-> (q.cnt <= q.bsize));

    // R3
    fetch_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_state == PS_FETCH) |-> !rx_ready);

endmodule

// File: tb/test_rx_desc_ring.sv
`timescale 1ns/1ps
module test_rx_desc_ring;
    localparam int AW     = 32;
    localparam int BSZ_W  = 11;
    localparam int MISS_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0, rx_enable = 1'b0;
    logic [AW-1:0] ring_base = 32'h100;
    logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
    logic [7:0] rx_data = 8'h0;
    logic rx_ready, mem_req, mem_we, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [3:0] mem_be;
    logic [2:0] proc_state;
    logic [MISS_W-1:0] missed_frames;

    always #4 clk = ~clk;

    rx_desc_ring #(.AW(AW), .BSZ_W(BSZ_W), .MISS_W(MISS_W)) i_rx_desc_ring (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rx_enable(rx_enable),
        .ring_base(ring_base), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err), .rx_ready(rx_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .proc_state(proc_state),
        .missed_frames(missed_frames));

    // memory model
    logic [31:0] mem [0:1023];
    logic ack_en = 1'b1;
    int   stall_mode = 0;
    int   tick = 0;
    assign mem_rdata = mem[mem_addr[11:2]];
    assign mem_ack   = mem_req && ack_en;

    always @(posedge clk)
        if (mem_req && mem_ack && mem_we)
            for (int b = 0; b < 4; b++)
                if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];

    always @(negedge clk) begin
        tick++;
        ack_en = (stall_mode == 0) ? 1'b1 : ((tick % 3) != 0 && (tick % 7) != 2);
    end

    // monitors
    int rd_cnt = 0, req_cnt = 0, hold_bad = 0;
    logic prev_pend = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    always @(posedge clk) begin
        if (rst_n && mem_req && mem_ack && !mem_we) rd_cnt++;
        if (rst_n && mem_req) req_cnt++;
        if (prev_pend && (!mem_req || mem_addr != prev_addr)) hold_bad++;
        prev_pend <= rst_n && mem_req && !mem_ack && !soft_rst;
        prev_addr <= mem_addr;
    end

    int n_chk = 0, n_bad = 0;
    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // ring model
    logic [31:0] dA [0:2];
    logic [31:0] bA [0:2];
    int sz [0:2];
    int nr = 3, ri = 0;

    function automatic logic [7:0] rbyte(input logic [31:0] a);
        return mem[a[11:2]][8*a[1:0] +: 8];
    endfunction

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'((seed * 7) + (k * 3) + 1);
    endfunction

    task automatic fill_buf(input logic [31:0] a);
        for (int w = 0; w < 32; w++) mem[a[11:2] + w[9:0]] = 32'hEEEE_EEEE;
    endtask

    task automatic build_ring();
        for (int i = 0; i < nr; i++) begin
            mem[dA[i][11:2]]     = 32'h8000_0000;
            mem[dA[i][11:2] + 1] = 32'(sz[i]) | ((i == nr - 1) ? 32'h0200_0000 : 32'h0);
            mem[dA[i][11:2] + 2] = bA[i];
            mem[dA[i][11:2] + 3] = 32'h0;
        end
    endtask

    task automatic send_frame(input int len, input bit err, input int seed);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = pat(seed, k);
            rx_sof   = (k == 0);
            rx_eof   = (k == len - 1);
            rx_err   = err && (k == len / 2);
            forever begin
                #3;
                if (rx_ready) begin
                    @(posedge clk);
                    break;
                end
                @(negedge clk);
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    endtask

    task automatic wait_idle();
        for (int t = 0; t < 500; t++) begin
            if (proc_state == 3'd2) break;
            @(negedge clk);
        end
    endtask

    task automatic owned_frame(input int len, input bit err, input int seed);
        int stored, bad, gbad;
        bit es;
        logic [31:0] d, b, exp;
        d = dA[ri]; b = bA[ri];
        fill_buf(b);
        send_frame(len, err, seed);
        wait_idle();
        stored = (len < sz[ri]) ? len : sz[ri];
        es     = err || (len > sz[ri]);
        exp    = {1'b0, 15'(stored), es, 6'b0, 1'b1, 8'b0};
        // R5 status layout, R7 error summary, R6 truncated length
        check(mem[d[11:2]] == exp, (len > sz[ri]) ? "R6" : (err ? "R7" : "R5"),
              $sformatf("status len=%0d size=%0d", len, sz[ri]), mem[d[11:2]], exp);
        bad = 0;
        for (int k = 0; k < stored; k++) if (rbyte(b + 32'(k)) != pat(seed, k)) bad++;
        check(bad == 0, "R4", $sformatf("payload len=%0d", len), 32'(bad), 32'd0);
        gbad = 0;
        for (int k = stored; k < stored + 4; k++) if (rbyte(b + 32'(k)) != 8'hEE) gbad++;
        check(gbad == 0, (len > sz[ri]) ? "R6" : "R4",
              $sformatf("guard bytes len=%0d", len), 32'(gbad), 32'd0);
        bad = 0;
        for (int j = 0; j < nr; j++)
            if (j != ri && mem[dA[j][11:2]] != 32'h8000_0000) bad++;
        // R8: only the current descriptor was consumed
        check(bad == 0, "R8", $sformatf("other descriptors len=%0d", len), 32'(bad), 32'd0);
        mem[d[11:2]] = 32'h8000_0000;
        ri = (ri + 1) % nr;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int rc0, mprev, rq0;
        logic [31:0] expm;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        dA[0] = 32'h100; dA[1] = 32'h110; dA[2] = 32'h120;
        bA[0] = 32'h400; bA[1] = 32'h500; bA[2] = 32'h600;
        sz[0] = 37; sz[1] = 64; sz[2] = 5;
        build_ring();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(proc_state == 3'd0, "R1", "state after reset", 32'(proc_state), 32'd0);
        check(missed_frames == 0, "R1", "missed after reset", 32'(missed_frames), 32'd0);
        check(!mem_req, "R2", "no request after reset", 32'(mem_req), 32'd0);

        rx_enable = 1'b1;
        repeat (2) @(negedge clk);
        check(proc_state == 3'd2, "R11", "waiting phase", 32'(proc_state), 32'd2);

        // R3 owned frame costs three reads
        rc0 = rd_cnt;
        owned_frame(8, 1'b0, 3);
        check(rd_cnt - rc0 == 3, "R3", "reads per owned frame", 32'(rd_cnt - rc0), 32'd3);

        // sweep lengths over every lane offset and across the buffer limits
        for (int len = 1; len <= 45; len++) begin
            stall_mode = len % 2;
            owned_frame(len, (len % 7) == 0, len);
        end
        stall_mode = 0;

        // R9 drops with saturation
        for (int n = 0; n < 9; n++) begin
            mem[dA[ri][11:2]] = 32'h0;
            fill_buf(bA[ri]);
            mprev = int'(missed_frames);
            rc0 = rd_cnt;
            send_frame(6, 1'b0, 9);
            wait_idle();
            expm = (mprev == 7) ? 32'd7 : 32'(mprev + 1);
            check(32'(missed_frames) == expm, "R9", "missed count", 32'(missed_frames), expm);
            check(mem[dA[ri][11:2]] == 32'h0, "R9", "unowned status untouched",
                  mem[dA[ri][11:2]], 32'h0);
            check(rbyte(bA[ri]) == 8'hEE, "R9", "buffer untouched", 32'(rbyte(bA[ri])), 32'hEE);
            check(rd_cnt - rc0 == 1, "R3", "reads per unowned frame", 32'(rd_cnt - rc0), 32'd1);
        end
        mem[dA[ri][11:2]] = 32'h8000_0000;
        owned_frame(12, 1'b0, 21);   // R9 same descriptor retried

        // R2 stopped
        rx_enable = 1'b0;
        repeat (3) @(negedge clk);
        check(proc_state == 3'd0, "R11", "stopped phase", 32'(proc_state), 32'd0);
        rq0 = req_cnt;
        send_frame(10, 1'b0, 5);
        repeat (5) @(negedge clk);
        check(req_cnt == rq0, "R2", "no memory traffic while stopped", 32'(req_cnt - rq0), 32'd0);
        rx_enable = 1'b1;
        repeat (2) @(negedge clk);

        // R1 soft reset with new single-entry ring at a different base
        dA[0] = 32'h200; bA[0] = 32'h700; sz[0] = 16; nr = 1; ri = 0;
        build_ring();
        ring_base = 32'h200;
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        check(proc_state == 3'd0, "R1", "state after soft reset", 32'(proc_state), 32'd0);
        check(missed_frames == 0, "R1", "missed after soft reset", 32'(missed_frames), 32'd0);
        repeat (2) @(negedge clk);
        owned_frame(20, 1'b0, 30);   // R8 wrap onto itself
        owned_frame(3, 1'b1, 31);
        check(mem[32'h100 >> 2] == 32'h8000_0000, "R1", "old ring untouched",
              mem[32'h100 >> 2], 32'h8000_0000);

        check(hold_bad == 0, "R10", "request held until ack", 32'(hold_bad), 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule